// File: doc/BRIEF.md
# Dual-Vector Aligning Right Shifter

This block right-shifts a redundant number, held as a sum vector and a carry vector, by a variable amount. Both vectors always move by the same distance, so their arithmetic total stays aligned. The same block serves two paths. On the accumulator path the shift amount is used as given. On the product path the amount arrives as the bitwise inverse of an exponent difference, and a sign input adds one further single-position step to finish the two's-complement negation.

The shifter is a chain of 2:1 multiplexer rows. Amount bit b drives a row that moves the data by 2^b positions. The low `STAGES` amount bits drive rows. Any set bit above them forces both results to zero, because such a distance is wider than the data. Both vectors are treated as two's complement, so each vacated upper bit takes a copy of that vector's own MSB. The outputs are registered, and each result appears on the clock edge after its operands are presented.

Top module: `dual_vec_rshift`

## Requirements
- R1: When amount bits [10:7] are all zero and no extra step applies, each output equals its input arithmetically right-shifted by amount[6:0] (upper bits filled with that vector's bit W-1).
- R2: The sum vector and the carry vector are always shifted by the same distance.
- R3: If any of amount bits [10:7] is 1, both outputs are all zeros, whatever the mode and sign inputs are.
- R4: When `prod_mode` is 1 and `neg_sel` is 1, the shift distance is amount[6:0] + 1.
- R5: When `prod_mode` is 0, `neg_sel` has no effect on either output.
- R6: When the amount is zero and no extra step applies, both outputs equal the inputs bit for bit.
- R7: The signed total sum_out + carry_out is at most 1 below the arithmetic right shift of the signed total sum_in + carry_in, and never above it.
- R8: While `rst_n` is low, both outputs are zero.
- R9: A result appears on the rising clock edge that captures its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sum_in | input | W | Sum vector, two's complement |
| carry_in | input | W | Carry vector, two's complement |
| amount | input | AMT_W | Shift distance (inverted difference on the product path) |
| neg_sel | input | 1 | Enables the extra one-position step on the product path |
| prod_mode | input | 1 | 1 selects the product-path variant |
| sum_out | output | W | Shifted sum vector, registered |
| carry_out | output | W | Shifted carry vector, registered |

## Verification
The assertions assume that every input is a known value at each rising edge once reset is released. They also assume that the data width is greater than the largest distance a single row can move, so the rows never overrun the vector. The bench keeps to these assumptions. It changes inputs only just after a falling edge and always drives complete values. It then sweeps the amount over zero, every single-row value, the boundaries near the data width, and random 11-bit values whose high bits are set.

// File: rtl/dual_vec_rshift.sv
module dual_vec_rshift #(
  parameter int W     = 107,
  parameter int AMT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     sum_in,
  input  logic [W-1:0]     carry_in,
  input  logic [AMT_W-1:0] amount,
  input  logic             neg_sel,
  input  logic             prod_mode,
  output logic [W-1:0]     sum_out,
  output logic [W-1:0]     carry_out
);
  localparam int STAGES = $clog2(W);

  logic [W-1:0] s_row [0:STAGES];
  logic [W-1:0] c_row [0:STAGES];
  logic         too_far;
  logic         extra;
  logic [W-1:0] s_fin, c_fin;

  assign s_row[0] = sum_in;
  assign c_row[0] = carry_in;

  for (genvar g = 0; g < STAGES; g++) begin : g_row
    localparam int SH = 1 << g;
    assign s_row[g+1] = amount[g] ? {{SH{s_row[g][W-1]}}, s_row[g][W-1:SH]} : s_row[g];
    assign c_row[g+1] = amount[g] ? {{SH{c_row[g][W-1]}}, c_row[g][W-1:SH]} : c_row[g];
  end

  assign too_far = |amount[AMT_W-1:STAGES];
  assign extra   = prod_mode & neg_sel;

  assign s_fin = too_far ? '0 :
                 extra   ? {s_row[STAGES][W-1], s_row[STAGES][W-1:1]} : s_row[STAGES];
  assign c_fin = too_far ? '0 :
                 extra   ? {c_row[STAGES][W-1], c_row[STAGES][W-1:1]} : c_row[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_out   <= '0;
      carry_out <= '0;
    end else begin
      sum_out   <= s_fin;
      carry_out <= c_fin;
    end
  end
endmodule

// File: rtl/dual_vec_rshift_chk.sv
module dual_vec_rshift_chk #(
  parameter int W     = 107,
  parameter int AMT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     sum_in,
  input logic [W-1:0]     carry_in,
  input logic [AMT_W-1:0] amount,
  input logic             neg_sel,
  input logic             prod_mode,
  input logic [W-1:0]     sum_out,
  input logic [W-1:0]     carry_out
);
  localparam int STAGES = $clog2(W);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|amount[AMT_W-1:STAGES]) |=> (sum_out == '0 && carry_out == '0));

  p_identity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (amount == '0 && !(prod_mode && neg_sel)) |=>
      (sum_out == $past(sum_in) && carry_out == $past(carry_in)));

  p_signkeep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (amount[AMT_W-1:STAGES] == '0) |=>
      (sum_out[W-1] == $past(sum_in[W-1]) && carry_out[W-1] == $past(carry_in[W-1])));

  p_extra_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (amount == '0 && prod_mode && neg_sel) |=>
      (sum_out == {$past(sum_in[W-1]), $past(sum_in[W-1:1])} &&
       carry_out == {$past(carry_in[W-1]), $past(carry_in[W-1:1])}));

  p_no_sign_effect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!prod_mode && amount == '0) |=> (sum_out == $past(sum_in)));
endmodule

bind dual_vec_rshift dual_vec_rshift_chk #(.W(W), .AMT_W(AMT_W)) u_chk (.*);

// File: tb/dual_vec_rshift_test.sv
module dual_vec_rshift_test;
  localparam int W = 107;
  localparam int AMT_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] sum_in = '0, carry_in = '0;
  logic [AMT_W-1:0] amount = '0;
  logic neg_sel = 1'b0, prod_mode = 1'b0;
  logic [W-1:0] sum_out, carry_out;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] q_es[$], q_ec[$], q_is[$], q_ic[$];
  int q_k[$];
  string q_tag[$];

  always #4 clk = ~clk;

  dual_vec_rshift #(.W(W), .AMT_W(AMT_W)) uut (
    .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .carry_in(carry_in),
    .amount(amount), .neg_sel(neg_sel), .prod_mode(prod_mode),
    .sum_out(sum_out), .carry_out(carry_out));

  function automatic logic [W-1:0] ashr(input logic [W-1:0] v, input int k);
    logic [W-1:0] r = v;
    for (int i = 0; i < k; i++) r = {r[W-1], r[W-1:1]};
    return r;
  endfunction

  function automatic logic [W-1:0] rnd();
    logic [127:0] x = {$urandom, $urandom, $urandom, $urandom};
    return x[W-1:0];
  endfunction

  task automatic drive(input logic [W-1:0] s, input logic [W-1:0] c,
                       input logic [AMT_W-1:0] a, input logic ns,
                       input logic pm, input string tag);
    int k;
    @(negedge clk);
    sum_in = s; carry_in = c; amount = a; neg_sel = ns; prod_mode = pm;
    k = (|a[AMT_W-1:7]) ? -1 : int'(a[6:0]) + ((pm && ns) ? 1 : 0);
    @(posedge clk);
    #1;
    q_es.push_back(k < 0 ? '0 : ashr(s, k));
    q_ec.push_back(k < 0 ? '0 : ashr(c, k));
    q_is.push_back(s); q_ic.push_back(c); q_k.push_back(k); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (q_es.size() > 0) begin
      logic [W-1:0] es, ec, is_, ic;
      int k;
      string tag;
      logic signed [W:0] tin, tref, tgot, diff;
      es = q_es.pop_front(); ec = q_ec.pop_front();
      is_ = q_is.pop_front(); ic = q_ic.pop_front();
      k = q_k.pop_front(); tag = q_tag.pop_front();
      checks++;
      if (sum_out !== es || carry_out !== ec) begin
        fails++;
        $display("FAIL %s: sum=%h carry=%h expected sum=%h carry=%h", tag, sum_out, carry_out, es, ec);
      end
      if (k >= 0) begin
        tin  = $signed({is_[W-1], is_}) + $signed({ic[W-1], ic});
        tref = tin >>> k;
        tgot = $signed({sum_out[W-1], sum_out}) + $signed({carry_out[W-1], carry_out});
        diff = tref - tgot;
        checks++;
        if (diff != 0 && diff != 1) begin
          fails++;
          $display("FAIL R7: total=%h expected %h (or one less)", tgot, tref);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b;
    sum_in = rnd(); carry_in = rnd(); amount = 11'd3;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sum_out !== '0 || carry_out !== '0) begin
      fails++;
      $display("FAIL R8: sum=%h carry=%h expected 0", sum_out, carry_out);
    end
    rst_n = 1'b1;

    a = rnd(); b = rnd();
    drive(a, b, 11'd0, 1'b0, 1'b0, "R6 zero amount");
    drive(a, b, 11'd0, 1'b1, 1'b0, "R5 sign ignored acc path");
    drive(a, b, 11'd0, 1'b1, 1'b1, "R4 extra step only");
    for (int g = 0; g < 7; g++)
      drive(rnd(), rnd(), AMT_W'(1 << g), 1'b0, 1'b0, "R1 single row");
    drive({1'b1, {(W-1){1'b0}}}, {1'b0, {(W-1){1'b1}}}, 11'd127, 1'b0, 1'b0, "R1 max low amount");
    drive({1'b1, {(W-1){1'b0}}}, {1'b0, {(W-1){1'b1}}}, 11'd106, 1'b0, 1'b0, "R2 width-1 boundary");
    drive(rnd(), rnd(), 11'd127, 1'b1, 1'b1, "R4 distance 128");
    drive(rnd(), rnd(), 11'd128, 1'b1, 1'b1, "R3 bit7 clears");
    drive(rnd(), rnd(), 11'h400, 1'b0, 1'b0, "R3 bit10 clears");
    for (int i = 0; i < 40; i++)
      drive(rnd(), rnd(), AMT_W'($urandom), 1'($urandom), 1'($urandom), "R9 random");
    for (int i = 0; i < 40; i++)
      drive(rnd(), rnd(), AMT_W'($urandom_range(0, 127)), 1'($urandom), 1'($urandom), "R2 random low");
    for (int i = 0; i < 10; i++) begin
      a = rnd(); b = rnd();
      drive(a, b, AMT_W'(i * 9), 1'b1, 1'b0, "R5 sign set");
      drive(a, b, AMT_W'(i * 9), 1'b0, 1'b0, "R5 sign clear");
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule